// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to a synchronous burst memory on every clock cycle. A new access begins when an address strobe is sampled while the chip is enabled. The external address is captured and appears on the output in the next cycle. After that, an internal beat counter rewrites the low address bits. The counter moves forward one beat on each cycle in which the advance input is high, and it never carries into the upper address bits.

There are two strobes, primary and secondary. Both load the same way when the chip is enabled. They differ only when the chip is disabled:

- A primary strobe with the chip disabled ends the current access, which is a deselect.
- A secondary strobe with the chip disabled is ignored.

A mode input, sampled together with the load, selects the stepping order:

- Linear order adds the beat count to the starting low bits, modulo the burst length.
- Interleaved order XORs the beat count into the starting low bits.

The interleaved order is selected by a low level, so a tied-off mode input gives interleaved stepping. Bursting is optional: a strobe on every cycle loads a fresh address every cycle, with no dead cycles.

Top module: `burst_addr_seq`

## Requirements
- R1: During and directly after reset, `addr_o` is all zeros and `burst_active` is 0.
- R2: A strobe (`strobe_pri` or `strobe_sec`) sampled with the chip enabled loads `addr_i`. From the next cycle, `addr_o` equals that address and `burst_active` is 1.
- R3: While a burst is active and no load or deselect occurs, the beat count advances by one, modulo 4, only on cycles where `adv` is 1. On all other cycles `addr_o` holds.
- R4: With `order_lin`=1 at load time, the two low bits of `addr_o` are (start low bits + beat) mod 4.
- R5: With `order_lin`=0 at load time, the two low bits of `addr_o` are (start low bits XOR beat). Level 0 is the tie-off default.
- R6: The order is captured at load. Changing `order_lin` during a burst does not alter that burst's sequence.
- R7: A load takes precedence over `adv`. Loading on consecutive cycles presents each new address one cycle after its strobe.
- R8: A sampled `strobe_pri` takes priority over `strobe_sec`. With the chip disabled, `strobe_pri` deselects: `burst_active` goes to 0 and `addr_o` holds. `strobe_sec` alone with the chip disabled is ignored.
- R9: While deselected, `adv` has no effect: `addr_o` and `burst_active` stay unchanged.
- R10: The chip counts as enabled only when `en_a`, `en_b` and `en_c` are all 1.
- R11: The upper address bits (all bits above the two low bits) remain those of the loaded address for the whole burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_a | input | 1 | Chip enable, first of three |
| en_b | input | 1 | Chip enable, second of three |
| en_c | input | 1 | Chip enable, third of three |
| strobe_pri | input | 1 | Primary address strobe; deselects when chip disabled |
| strobe_sec | input | 1 | Secondary address strobe; ignored when chip disabled |
| adv | input | 1 | Advance the burst by one beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current memory word address |
| burst_active | output | 1 | An access is in progress |

## Verification
The bench starts linear bursts at every low offset and steps each one past the fourth beat. A design that carried into the upper bits, or stopped at the top of the burst instead of wrapping, would show a wrong high address or a stuck address. It also starts interleaved bursts from nonzero offsets and interleaves idle cycles, which exposes designs that add where they should XOR, or that step without `adv`. It flips the mode input in the middle of a burst, which exposes designs that use the live pin instead of the captured order. It also drives both strobes with each enable dropped in turn: a design with inverted strobe priority would keep the burst alive, and a design that ignores one enable would load.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_DESEL = 2'd2,
        ACT_STEP  = 2'd3
    } seq_act_e;
endpackage

// File: rtl/burst_seq_decode.sv
module burst_seq_decode
    import burst_addr_seq_pkg::*;
(
    input  logic     strobe_pri,
    input  logic     strobe_sec,
    input  logic     en_all,
    input  logic     active,
    input  logic     adv,
    output seq_act_e act
);
    // Primary strobe is examined first; it decides alone when present.
    always_comb begin
        if (strobe_pri) begin
            act = en_all ? ACT_LOAD : ACT_DESEL;
        end else if (strobe_sec && en_all) begin
            act = ACT_LOAD;
        end else if (active && adv) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end
endmodule

// File: rtl/burst_low_order.sv
module burst_low_order #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] count,
    input  logic              lin,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Sum truncated to BEAT_W bits: wraps inside the burst, no carry out.
    assign lin_low = start + count;

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv
            assign ilv_low[gi] = start[gi] ^ count[gi];
        end
    endgenerate

    assign low = lin ? lin_low : ilv_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              en_c,
    input  logic              strobe_pri,
    input  logic              strobe_sec,
    input  logic              adv,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              burst_active
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic              lin;
        logic              active;
    } seq_st_t;

    seq_st_t  st_d, st_q;
    seq_act_e act;
    logic     en_all;
    logic [BEAT_W-1:0] low_bits;

    assign en_all = en_a & en_b & en_c;

    burst_seq_decode u_dec (
        .strobe_pri (strobe_pri),
        .strobe_sec (strobe_sec),
        .en_all     (en_all),
        .active     (st_q.active),
        .adv        (adv),
        .act        (act)
    );

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_LOAD: begin
                st_d.base   = addr_i;
                st_d.beat   = '0;
                st_d.lin    = order_lin;
                st_d.active = 1'b1;
            end
            ACT_DESEL: st_d.active = 1'b0;
            ACT_STEP:  st_d.beat   = st_q.beat + 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_low_order #(.BEAT_W(BEAT_W)) u_low (
        .start (st_q.base[BEAT_W-1:0]),
        .count (st_q.beat),
        .lin   (st_q.lin),
        .low   (low_bits)
    );

    assign addr_o       = {st_q.base[ADDR_W-1:BEAT_W], low_bits};
    assign burst_active = st_q.active;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_a,
    input logic              en_b,
    input logic              en_c,
    input logic              strobe_pri,
    input logic              strobe_sec,
    input logic              adv,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              burst_active
);
    logic en3;
    assign en3 = en_a & en_b & en_c;

    // R2 R10: an enabled strobe presents the captured address next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en3 && (strobe_pri || strobe_sec)) |=> (burst_active && addr_o == $past(addr_i)));

    // R3: no advance and no strobe keeps the address still
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !strobe_pri && !(strobe_sec && en3)) |=> $stable(addr_o));

    // R11: upper bits never move inside a burst
    p_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !strobe_pri && !(strobe_sec && en3))
        |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    // R8: primary strobe while disabled deselects, whatever the secondary does
    p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_pri && !en3) |=> (!burst_active && $stable(addr_o)));

    // R9: idle stays idle when nothing loads
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && !strobe_pri && !(strobe_sec && en3)) |=> !burst_active);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_a         (en_a),
    .en_b         (en_b),
    .en_c         (en_c),
    .strobe_pri   (strobe_pri),
    .strobe_sec   (strobe_sec),
    .adv          (adv),
    .addr_i       (addr_i),
    .addr_o       (addr_o),
    .burst_active (burst_active)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_a = 1'b0, en_b = 1'b0, en_c = 1'b0;
    logic          strobe_pri = 1'b0, strobe_sec = 1'b0, adv = 1'b0, order_lin = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic          burst_active;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    int m_base = 0, m_beat = 0;
    bit m_act = 0, m_lin = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .en_c(en_c),
        .strobe_pri(strobe_pri), .strobe_sec(strobe_sec), .adv(adv),
        .order_lin(order_lin), .addr_i(addr_i), .addr_o(addr_o),
        .burst_active(burst_active)
    );

    function automatic int exp_addr();
        int lo;
        if (m_lin) lo = ((m_base & 3) + m_beat) % 4;
        else       lo = (m_base & 3) ^ m_beat;
        return (m_base & ~3) | lo;
    endfunction

    task automatic compare(string tag);
        int ea;
        ea = exp_addr();
        total++;
        if (addr_o !== ea[AW-1:0] || burst_active !== m_act) begin
            bad++;
            $display("FAIL %s: addr=%h act=%0b expected addr=%h act=%0b",
                     tag, addr_o, burst_active, ea[AW-1:0], m_act);
        end
    endtask

    task automatic cyc(bit p, bit s, bit a, bit [2:0] en, bit lin, int ad, string tag);
        bit e;
        strobe_pri = p; strobe_sec = s; adv = a;
        {en_a, en_b, en_c} = en; order_lin = lin; addr_i = ad[AW-1:0];
        @(posedge clk);
        e = (en == 3'b111);
        if (p) begin
            if (e) begin m_base = ad; m_beat = 0; m_lin = lin; m_act = 1; end
            else m_act = 0;
        end else if (s && e) begin
            m_base = ad; m_beat = 0; m_lin = lin; m_act = 1;
        end else if (m_act && a) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // R2 R4 R11: linear from every offset, six advances to wrap
        for (int off = 0; off < 4; off++) begin
            cyc(1, 0, 0, 3'b111, 1, 'h5A3C0 + off, "R2 load primary");
            for (int k = 0; k < 6; k++) cyc(0, 0, 1, 3'b111, 1, 'h0F0F3, "R4 R11 linear step");
        end

        // R5 R3: interleaved via secondary, with pauses
        for (int off = 0; off < 4; off++) begin
            cyc(0, 1, 0, 3'b111, 0, 'h3C5A4 + off, "R2 load secondary");
            for (int k = 0; k < 6; k++) begin
                cyc(0, 0, 1, 3'b111, 1, 0, "R5 interleaved step");
                cyc(0, 0, 0, 3'b111, 1, 0, "R3 hold no adv");
            end
        end

        // R6: mode flips mid burst
        cyc(1, 0, 0, 3'b111, 1, 'h00011, "R6 load linear");
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 3'b111, k[0], 0, "R6 mode ignored");
        cyc(1, 0, 0, 3'b111, 0, 'h00012, "R6 load interleaved");
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 3'b111, ~k[0], 0, "R6 mode ignored");

        // R7: loads each cycle with adv high
        for (int k = 0; k < 8; k++) cyc(k[0], ~k[0], 1, 3'b111, k[1], 'h12340 + k * 5, "R7 back to back");

        // R8 R10: each enable low; secondary ignored, primary deselects
        for (int d = 0; d < 3; d++) begin
            bit [2:0] en = 3'b111;
            en[d] = 1'b0;
            cyc(1, 0, 0, 3'b111, 1, 'h0ABC1, "R8 start");
            cyc(0, 1, 0, en, 0, 'h77777, "R10 secondary disabled ignored");
            cyc(0, 0, 1, 3'b111, 0, 0, "R8 burst continues");
            cyc(1, 1, 1, en, 0, 'h66666, "R8 primary wins deselect");
            // R9 adv while deselected
            cyc(0, 0, 1, 3'b111, 0, 0, "R9 adv while idle");
            cyc(0, 1, 1, en, 1, 'h55555, "R9 R10 no load");
        end

        // mixed stimulus
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom;
            cyc(r[0] & r[1], r[2] & r[3], r[4], {r[5] | r[6], r[7] | r[8], r[9] | r[10]},
                r[11], r[31:12], "R3 R8 mixed");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule